// File: doc/BRIEF.md
# Packet Page Allocator

This block hands out slots from a small pool of fixed-size packet pages. An occupancy bitmap has one bit per page. Two clients request pages: the receive path, which wants a page for each incoming frame, and a software command that reserves a page for a frame to be transmitted. Each request is given the lowest-numbered page that is free. When every page is taken, the request gets the failure code 0x80 instead of a page index.

A transmit reservation that fails is not dropped. The failure code is kept as the transmit result, and the next page release retries the reservation in that same cycle. A successful transmit reservation sets an allocation-done flag, which is meant to drive an interrupt. The block also reports how many pages are in use and the fixed size of the pool. A memory-reset command empties the pool in a single cycle.

Top module: `pkt_page_alloc`

## Requirements
- R1: After a synchronous reset, the in-use count is 0, the transmit result is 0, the allocation-done flag is 0 and no receive grant is valid.
- R2: A request is granted the lowest-numbered free page, and that page is marked used. The grant appears on the registered outputs one cycle after the request is sampled. Page indices are zero-extended into an 8-bit result.
- R3: When no page is free, the result of a request is 0x80 and the bitmap does not change.
- R4: A transmit-allocate command clears the allocation-done flag and then attempts a reservation. If the attempt fails, the transmit result is 0x80 and the flag stays at 0.
- R5: Only a successful transmit reservation sets the allocation-done flag. The acknowledge input clears the flag. If a success and an acknowledge arrive in the same cycle, the flag ends up set.
- R6: A release clears the bit of the named page. Releasing a page that is not in use has no effect. If the transmit result is 0x80 when a release arrives, the transmit reservation is retried in that same cycle.
- R7: When receive and transmit requests are served in the same cycle, the receive request takes a page first. The transmit request is served from the pages that remain.
- R8: The in-use count equals the number of used pages after each cycle. The pool-size output is the constant page count, 4 by default.
- R9: A memory-reset command empties the bitmap and sets the transmit result to 0. Requests and releases arriving in the same cycle are ignored, and no receive grant is valid for that cycle.
- R10: A release is applied before the allocations of the same cycle, so a page freed in one cycle can be granted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_req | input | 1 | Receive path requests a page |
| tx_alloc_cmd | input | 1 | Software transmit-allocate command |
| rel_req | input | 1 | Release the page named by rel_page |
| rel_page | input | 2 | Index of the page to release |
| mem_reset_cmd | input | 1 | Empty the pool and set the transmit result to 0 |
| alloc_done_ack | input | 1 | Clear the allocation-done flag |
| rx_grant_vld | output | 1 | A receive result is valid this cycle |
| rx_grant | output | 8 | Receive result: page index, or 0x80 if none is free |
| tx_result | output | 8 | Transmit result: page index, 0x80 if failed or pending |
| alloc_done | output | 1 | Allocation-done interrupt flag |
| used_count | output | 3 | Number of pages in use |
| total_pages | output | 3 | Size of the pool |

## Verification
Every state element of this block can be seen at the ports one cycle after it changes. A lost or stale bitmap bit shows up at once as a wrong in-use count. It then shows up as a skipped or duplicated page index on the next grant. A pending transmit reservation that is not retried correctly shows up as 0x80 held on the transmit result, or as a missing flag, in the cycle right after a release. The bench covers this with a release while full, a release together with a receive request, and a release of a page that is already free.

// File: rtl/page_alloc_pkg.sv
package page_alloc_pkg;
  localparam int RES_W = 8;
  typedef logic [RES_W-1:0] page_res_t;
  localparam page_res_t NO_PAGE = 8'h80;
endpackage

// File: rtl/page_lowest_free.sv
module page_lowest_free #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  occ,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign onehot[g]  = ~occ[g] & ~seen[g];
    assign seen[g+1]  = seen[g] | ~occ[g];
  end

  assign found = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/page_popcount.sv
module page_popcount #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(bits[i]);
  end
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import page_alloc_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int CNT_W = $clog2(NUM_PAGES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_req,
  input  logic             tx_alloc_cmd,
  input  logic             rel_req,
  input  logic [IDX_W-1:0] rel_page,
  input  logic             mem_reset_cmd,
  input  logic             alloc_done_ack,
  output logic             rx_grant_vld,
  output logic [7:0]       rx_grant,
  output logic [7:0]       tx_result,
  output logic             alloc_done,
  output logic [CNT_W-1:0] used_count,
  output logic [CNT_W-1:0] total_pages
);
  logic [NUM_PAGES-1:0] bitmap, after_rel, after_rx, bitmap_next, rel_mask;
  logic [NUM_PAGES-1:0] rx_oh, tx_oh;
  logic [IDX_W-1:0]     rx_idx, tx_idx;
  logic                 rx_found, tx_found, tx_try;
  logic [CNT_W-1:0]     cnt_next;

  assign total_pages = CNT_W'(NUM_PAGES);

  // release takes effect before allocations of the same cycle
  assign rel_mask  = rel_req ? (NUM_PAGES'(1) << rel_page) : '0;
  assign after_rel = bitmap & ~rel_mask;

  page_lowest_free #(.N(NUM_PAGES), .IW(IDX_W)) u_rx_pick (
    .occ(after_rel), .found(rx_found), .idx(rx_idx), .onehot(rx_oh));

  assign after_rx = (rx_req && rx_found) ? (after_rel | rx_oh) : after_rel;

  page_lowest_free #(.N(NUM_PAGES), .IW(IDX_W)) u_tx_pick (
    .occ(after_rx), .found(tx_found), .idx(tx_idx), .onehot(tx_oh));

  // a failed transmit reservation is retried whenever a page is released
  assign tx_try = tx_alloc_cmd || (rel_req && (tx_result == NO_PAGE));

  always_comb begin
    if (mem_reset_cmd)            bitmap_next = '0;
    else if (tx_try && tx_found)  bitmap_next = after_rx | tx_oh;
    else                          bitmap_next = after_rx;
  end

  page_popcount #(.N(NUM_PAGES), .CW(CNT_W)) u_cnt (
    .bits(bitmap_next), .cnt(cnt_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      bitmap       <= '0;
      used_count   <= '0;
      tx_result    <= '0;
      alloc_done   <= 1'b0;
      rx_grant_vld <= 1'b0;
      rx_grant     <= '0;
    end else begin
      bitmap     <= bitmap_next;
      used_count <= cnt_next;
      if (mem_reset_cmd) begin
        tx_result    <= '0;
        rx_grant_vld <= 1'b0;
      end else begin
        rx_grant_vld <= rx_req;
        if (rx_req) rx_grant <= rx_found ? page_res_t'(rx_idx) : NO_PAGE;
        if (tx_try) tx_result <= tx_found ? page_res_t'(tx_idx) : NO_PAGE;
        if (tx_try && tx_found)                alloc_done <= 1'b1;
        else if (tx_alloc_cmd || alloc_done_ack) alloc_done <= 1'b0;
      end
    end
  end

  // R3: a failed receive grant means the pool was full
  a_r3_fail_only_full: assert property (@(posedge clk) disable iff (rst)
    (rx_grant_vld && rx_grant == NO_PAGE) |-> used_count == CNT_W'(NUM_PAGES));

  // R5: flag rises only together with a real page in the transmit result
  a_r5_done_has_page: assert property (@(posedge clk) disable iff (rst)
    $rose(alloc_done) |-> tx_result != NO_PAGE);

  // R6: a pending transmit failure can only persist while the pool is full
  a_r6_pending_when_full: assert property (@(posedge clk) disable iff (rst)
    (tx_result == NO_PAGE) |-> used_count == CNT_W'(NUM_PAGES));

  // R8: the registered count tracks the bitmap
  a_r8_count_matches: assert property (@(posedge clk) disable iff (rst)
    used_count == CNT_W'($countones(bitmap)));

  // R9: memory reset empties the pool and zeroes the transmit result
  a_r9_mem_reset: assert property (@(posedge clk) disable iff (rst)
    mem_reset_cmd |=> (used_count == '0 && tx_result == '0 && !rx_grant_vld));
endmodule

// File: tb/sim_pkt_page_alloc.sv
module sim_pkt_page_alloc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_req = 0, tx_alloc_cmd = 0, rel_req = 0, mem_reset_cmd = 0, alloc_done_ack = 0;
  logic [1:0] rel_page = '0;
  logic rx_grant_vld, alloc_done;
  logic [7:0] rx_grant, tx_result;
  logic [2:0] used_count, total_pages;

  always #2 clk = ~clk;

  pkt_page_alloc u0 (.*);

  typedef struct {
    int due; string tag;
    logic rxv; logic [7:0] rxp; logic [7:0] txr; logic done; logic [2:0] cnt;
  } exp_t;
  exp_t q[$];

  int cyc = 0, n_cmp = 0, n_bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference state
  logic [3:0] m_map = '0;
  logic [7:0] m_txr = '0;
  logic       m_done = 0;

  function automatic logic [7:0] take(inout logic [3:0] mp);
    for (int i = 0; i < 4; i++) if (!mp[i]) begin mp[i] = 1'b1; return 8'(i); end
    return 8'h80;
  endfunction

  task automatic step(input logic rx, input logic tx, input logic rel, input logic [1:0] rp,
                      input logic mr, input logic ack, input string tag);
    exp_t e;
    logic [7:0] r;
    logic tr;
    @(posedge clk); #1;
    rx_req = rx; tx_alloc_cmd = tx; rel_req = rel; rel_page = rp;
    mem_reset_cmd = mr; alloc_done_ack = ack;
    e.rxv = 0; e.rxp = 0;
    if (mr) begin
      m_map = '0; m_txr = 8'h00;
    end else begin
      if (rel) m_map[rp] = 1'b0;
      if (rx) begin e.rxv = 1; e.rxp = take(m_map); end
      tr = tx || (rel && m_txr == 8'h80);
      r = 8'h80;
      if (tr) begin r = take(m_map); m_txr = r; end
      if (tr && r != 8'h80) m_done = 1;
      else if (tx || ack) m_done = 0;
    end
    e.due = cyc + 1; e.tag = tag; e.txr = m_txr; e.done = m_done;
    e.cnt = 3'($countones(m_map));
    q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string f, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, f, act, exp);
    end
  endtask

  // monitor: compare results in the cycle they are due
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "rx_grant_vld", int'(rx_grant_vld), int'(e.rxv));
      if (e.rxv) cmp(e.tag, "rx_grant", int'(rx_grant), int'(e.rxp));
      cmp(e.tag, "tx_result", int'(tx_result), int'(e.txr));
      cmp(e.tag, "alloc_done", int'(alloc_done), int'(e.done));
      cmp(e.tag, "used_count", int'(used_count), int'(e.cnt));
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        step(0,0,0,0,0,0,"R1");
        step(1,0,0,0,0,0,"R2");           // rx -> page 0
        step(0,1,0,0,0,0,"R2_R4");        // tx -> page 1, flag set
        step(0,0,0,0,0,1,"R5");           // ack clears flag
        step(1,0,0,0,0,0,"R2");           // page 2
        step(1,0,0,0,0,0,"R2");           // page 3
        step(1,0,0,0,0,0,"R3");           // full -> 0x80
        step(0,1,0,0,0,0,"R4");           // tx fails, pending
        step(0,0,0,0,0,0,"R8");
        step(0,0,1,2'd2,0,0,"R6");        // retry takes page 2
        step(1,0,1,2'd0,0,0,"R10");       // freed page 0 regranted
        step(0,1,0,0,0,0,"R4");           // full: pending again
        step(1,0,1,2'd1,0,0,"R7");        // rx beats pending retry
        step(0,0,0,0,1,0,"R9");           // memory reset
        step(1,1,0,0,0,0,"R7");           // rx 0, tx 1
        step(0,0,1,2'd3,0,0,"R6");        // release free page: no change
        step(1,1,0,0,0,1,"R5");           // success beats ack
        step(1,1,1,2'd0,1,0,"R9");        // reset ignores the rest
        step(0,0,1,2'd0,0,0,"R6");        // release on empty pool
        step(0,0,0,0,0,0,"R1");
        repeat (3) @(posedge clk);
        n_cmp++;
        if (total_pages != 3'd4) begin
          n_bad++;
          $display("FAIL R8 total_pages actual=%0d expected=4", total_pages);
        end
        if (q.size() != 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R2 pending_results actual=%0d expected=0", q.size());
        end
      end
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R1 watchdog actual=expired expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule